// File: doc/BRIEF.md
# Sectored External Memory Wait-State Controller

This block serves host accesses to addresses above the top of internal SRAM. It runs each one as a transfer on an external parallel memory bus. A transfer has three parts: an address cycle marked by an address-latch pulse, a strobe interval where the read or write strobe is low, and a release cycle. The host sees `busy_o` for the whole transfer. Accesses at or below the internal SRAM top are left alone, and so is every access while the block is disabled.

A programmable boundary splits the external space into a lower sector and an upper sector. Each sector has its own 2-bit wait-state code. The code lengthens the strobe and, for the slowest code, adds one address-hold cycle at the end. Only a programmable number of the high address lines are driven; the rest are released. An optional keeper holds the last data-bus value while nothing drives the bus. Configuration is sampled only while no transfer is running, so a transfer runs to its end with the settings it started with.

Top module: `xmem_ws_ctrl`

## Requirements
- R1: While `cfg_en_i` is 0, a request is not accepted: `busy_o`, `ale_o`, `rd_no` and `wr_no` stay inactive.
- R2: Only addresses strictly greater than `INT_TOP` (default 0x10FF) start a transfer. An address at or below it is ignored.
- R3: An address greater than or equal to `cfg_bound_i` uses `cfg_ws_hi_i`. A lower external address uses `cfg_ws_lo_i`.
- R4: Wait code 0, 1, 2 or 3 keeps the active strobe low for 1, 2, 3 or 3 cycles. `busy_o` lasts 3, 4, 5 or 6 cycles respectively.
- R5: Code 3 adds one cycle after the release cycle. In that cycle both strobes are high and the address is still presented.
- R6: `ale_o` is high for exactly the first cycle of a transfer, with the low address byte already on `ext_addr_lo_o`.
- R7: A read samples `ext_data_i` in the last strobe-low cycle. It presents the value on `rdata_o` with a one-cycle `rvalid_o` pulse in the following cycle. A write gives no `rvalid_o`.
- R8: A write drives `wdata_i` on `ext_data_o` with `ext_data_oe_o` high from the first strobe cycle through the release cycle. That is one cycle longer than the strobe.
- R9: With `cfg_hi_bits_i` = n, the low min(n, 8) bits of the high address byte are driven with `ext_addr_hi_oe_o` set. The other lines have output enable 0 and value 0.
- R10: With `cfg_keep_i` = 1 and the data bus not driven, `keep_o` is 1 and `ext_data_o` repeats the last value on the bus (the last write data or the last sampled read data). With `cfg_keep_i` = 0, `keep_o` is 0 and `ext_data_o` is 0 when not driving.
- R11: Changes to any configuration input during a transfer do not alter that transfer's timing, high-address lines or keeper setting.
- R12: `rd_no` and `wr_no` are never low together. Requests arriving while `busy_o` is high are ignored, and the address on the bus stays that of the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_en_i | input | 1 | External bus enable |
| cfg_bound_i | input | ADDR_W | First address of the upper sector |
| cfg_ws_lo_i | input | 2 | Wait code, lower sector |
| cfg_ws_hi_i | input | 2 | Wait code, upper sector |
| cfg_hi_bits_i | input | CNT_W | Number of high address lines driven |
| cfg_keep_i | input | 1 | Data-bus keeper enable |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host address |
| wdata_i | input | DATA_W | Host write data |
| busy_o | output | 1 | Transfer in progress |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid pulse |
| ale_o | output | 1 | Address-latch pulse |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ext_addr_lo_o | output | 8 | Low address byte |
| ext_addr_hi_o | output | HI_W | High address lines |
| ext_addr_hi_oe_o | output | HI_W | Per-line drive enable for high address lines |
| ext_data_o | output | DATA_W | Data bus out |
| ext_data_oe_o | output | 1 | Data bus drive enable |
| ext_data_i | input | DATA_W | Data bus in |
| keep_o | output | 1 | Keeper holding the data bus |

## Verification
The hardest case to reach is a configuration change that lands inside a running transfer. A wrong design that latches settings every cycle looks correct whenever the inputs are quiet. The stimulus therefore starts a slow lower-sector read and then, in the cycle after acceptance, rewrites the wait code, the high-line count and the keeper enable. It then checks that the strobe length, the busy length and the high-address enables still match the old settings. The read-sample point is checked with a memory model whose data changes every strobe cycle, so only a sample in the last strobe cycle gives the expected value.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_REL,
    ST_HOLD
  } xstate_e;

  // extra strobe cycles per wait code
  function automatic logic [1:0] ws_extra(input logic [1:0] code);
    case (code)
      2'd0:    ws_extra = 2'd0;
      2'd1:    ws_extra = 2'd1;
      default: ws_extra = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/xmem_sector_sel.sv
module xmem_sector_sel #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h10FF
) (
  input  logic              en_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] bound_i,
  input  logic [1:0]        ws_lo_i,
  input  logic [1:0]        ws_hi_i,
  output logic              hit_o,
  output logic [1:0]        code_o
);
  logic is_ext, is_upper;

  always_comb begin
    is_ext   = addr_i > INT_TOP;
    is_upper = addr_i >= bound_i;
    hit_o    = en_i && req_i && is_ext;
    code_o   = is_upper ? ws_hi_i : ws_lo_i;
  end
endmodule

// File: rtl/xmem_hi_mask.sv
module xmem_hi_mask #(
  parameter int HI_W = 8,
  parameter int CNT_W = $clog2(HI_W + 1)
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [HI_W-1:0]  mask_o
);
  for (genvar i = 0; i < HI_W; i++) begin : g_line
    assign mask_o[i] = (cnt_i > CNT_W'(i));
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] code_i,
  input  logic [1:0] code_q_i,
  output xstate_e    state_o,
  output logic       strb_last_o
);
  xstate_e    state_q;
  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ADDR;
          cnt_q   <= ws_extra(code_i);
        end
        ST_ADDR: state_q <= ST_STRB;
        ST_STRB: begin
          if (cnt_q == '0) state_q <= ST_REL;
          else             cnt_q   <= cnt_q - 2'd1;
        end
        ST_REL:  state_q <= (code_q_i == 2'd3) ? ST_HOLD : ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign strb_last_o = (state_q == ST_STRB) && (cnt_q == '0);

  // strobe-low cycles measured independently of the down-counter
  logic [2:0] len_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 len_q <= '0;
    else if (state_q == ST_STRB) len_q <= len_q + 3'd1;
    else                         len_q <= '0;
  end

  assert_strobe_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REL && len_q != '0) |-> (len_q == 3'(ws_extra(code_q_i)) + 3'd1));

  assert_hold_only_slow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |-> (code_q_i == 2'd3));
endmodule

// File: rtl/xmem_ws_ctrl.sv
module xmem_ws_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h10FF,
  localparam int HI_W = ADDR_W - 8,
  localparam int CNT_W = $clog2(HI_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_bound_i,
  input  logic [1:0]        cfg_ws_lo_i,
  input  logic [1:0]        cfg_ws_hi_i,
  input  logic [CNT_W-1:0]  cfg_hi_bits_i,
  input  logic              cfg_keep_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic [7:0]        ext_addr_lo_o,
  output logic [HI_W-1:0]   ext_addr_hi_o,
  output logic [HI_W-1:0]   ext_addr_hi_oe_o,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe_o,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              keep_o
);
  logic              hit, start, strb_last;
  logic [1:0]        sel_code, code_q;
  xstate_e           state;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, keep_val_q, rdata_q;
  logic              we_q, rvalid_q, en_q, keep_en_q;
  logic [CNT_W-1:0]  hi_cnt_q;
  logic [HI_W-1:0]   hi_mask;

  xmem_sector_sel #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_sel (
    .en_i    (cfg_en_i),
    .req_i   (req_i),
    .addr_i  (addr_i),
    .bound_i (cfg_bound_i),
    .ws_lo_i (cfg_ws_lo_i),
    .ws_hi_i (cfg_ws_hi_i),
    .hit_o   (hit),
    .code_o  (sel_code)
  );

  assign start = (state == ST_IDLE) && hit;

  xmem_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .code_i      (sel_code),
    .code_q_i    (code_q),
    .state_o     (state),
    .strb_last_o (strb_last)
  );

  xmem_hi_mask #(.HI_W(HI_W), .CNT_W(CNT_W)) u_mask (
    .cnt_i  (hi_cnt_q),
    .mask_o (hi_mask)
  );

  // configuration shadow: follows inputs only between transfers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      hi_cnt_q  <= '0;
      keep_en_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      en_q      <= cfg_en_i;
      hi_cnt_q  <= cfg_hi_bits_i;
      keep_en_q <= cfg_keep_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      code_q  <= '0;
    end else if (start) begin
      addr_q  <= addr_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
      code_q  <= sel_code;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      keep_val_q <= '0;
    end else begin
      rvalid_q <= strb_last && !we_q;
      if (strb_last && !we_q) begin
        rdata_q    <= ext_data_i;
        keep_val_q <= ext_data_i;
      end else if (state == ST_ADDR && we_q) begin
        keep_val_q <= wdata_q;
      end
    end
  end

  always_comb begin
    busy_o           = (state != ST_IDLE);
    ale_o            = (state == ST_ADDR);
    rd_no            = !((state == ST_STRB) && !we_q);
    wr_no            = !((state == ST_STRB) && we_q);
    ext_data_oe_o    = we_q && ((state == ST_STRB) || (state == ST_REL));
    ext_addr_lo_o    = addr_q[7:0];
    ext_addr_hi_oe_o = en_q ? hi_mask : '0;
    ext_addr_hi_o    = addr_q[ADDR_W-1:8] & ext_addr_hi_oe_o;
    keep_o           = keep_en_q && !ext_data_oe_o;
    if (ext_data_oe_o)  ext_data_o = wdata_q;
    else if (keep_o)    ext_data_o = keep_val_q;
    else                ext_data_o = '0;
    rdata_o          = rdata_q;
    rvalid_o         = rvalid_q;
  end

  assert_disabled_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cfg_en_i) |=> !busy_o);

  assert_ale_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && busy_o));

  assert_rvalid_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> ($past(!rd_no) && rd_no));

  assert_wdata_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (ext_data_oe_o && ext_data_o == wdata_q));

  assert_released_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_addr_hi_o & ~ext_addr_hi_oe_o) == '0);

  assert_keeper_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    keep_o |-> !ext_data_oe_o);

  assert_cfg_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(code_q) && $stable(hi_cnt_q) && $stable(keep_en_q)));

  assert_no_dual_strobe_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no));

  assert_addr_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ext_addr_lo_o));
endmodule

// File: tb/xmem_ws_ctrl_bench.sv
`timescale 1ns/1ps
module xmem_ws_ctrl_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_en = 1'b0, cfg_keep = 1'b0;
  logic [15:0] cfg_bound = 16'h8000;
  logic [1:0]  cfg_ws_lo = 2'd0, cfg_ws_hi = 2'd0;
  logic [3:0]  cfg_hi_bits = 4'd8;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, rvalid, ale, rd_n, wr_n, data_oe, keep;
  logic [7:0]  rdata, a_lo, a_hi, a_hi_oe, d_out, d_in;
  logic [2:0]  rd_cnt;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  xmem_ws_ctrl u_xmem_ws_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_bound_i(cfg_bound),
    .cfg_ws_lo_i(cfg_ws_lo), .cfg_ws_hi_i(cfg_ws_hi), .cfg_hi_bits_i(cfg_hi_bits),
    .cfg_keep_i(cfg_keep), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .busy_o(busy), .rdata_o(rdata), .rvalid_o(rvalid), .ale_o(ale), .rd_no(rd_n),
    .wr_no(wr_n), .ext_addr_lo_o(a_lo), .ext_addr_hi_o(a_hi), .ext_addr_hi_oe_o(a_hi_oe),
    .ext_data_o(d_out), .ext_data_oe_o(data_oe), .ext_data_i(d_in), .keep_o(keep)
  );

  // memory model: data changes every strobe cycle
  always_ff @(posedge clk) rd_cnt <= rd_n ? 3'd0 : rd_cnt + 3'd1;
  assign d_in = (a_lo ^ 8'h5A) + {5'd0, rd_cnt};

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // transfer results
  int n_busy, n_rd, n_wr, n_ale, n_oe, n_rv, n_dual, n_drift, n_wbad, n_hold_ok;
  logic [7:0] got, hi_snap, hioe_snap, ale_lo;

  // poke: 1 = rewrite configuration right after acceptance
  // stay: 1 = keep requesting another address while busy
  task automatic xfer(input bit w, input logic [15:0] a, input logic [7:0] d,
                      input bit poke, input bit stay);
    n_busy = 0; n_rd = 0; n_wr = 0; n_ale = 0; n_oe = 0; n_rv = 0;
    n_dual = 0; n_drift = 0; n_wbad = 0; n_hold_ok = 0; got = '0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    if (stay) begin addr = a ^ 16'h00F0; we = ~w; end
    else req = 1'b0;
    if (poke) begin cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd0; cfg_hi_bits = 4'd0; cfg_keep = 1'b0; end
    for (int i = 0; i < 40 && busy; i++) begin
      n_busy++;
      if (ale) begin n_ale++; ale_lo = a_lo; hi_snap = a_hi; hioe_snap = a_hi_oe; end
      if (!rd_n) n_rd++;
      if (!wr_n) begin n_wr++; if (d_out != d) n_wbad++; end
      if (!rd_n && !wr_n) n_dual++;
      if (data_oe) n_oe++;
      if (rvalid) begin n_rv++; got = rdata; end
      if (a_lo != a[7:0]) n_drift++;
      if (i == 5 && rd_n && wr_n && !ale && a_lo == a[7:0]) n_hold_ok++;
      @(negedge clk);
    end
    req = 1'b0;
    if (rvalid) begin n_rv++; got = rdata; end
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset strobes", {rd_n, wr_n, ale}, 3'b110);
    chk("R9 reset hi oe", a_hi_oe, 0);
  endtask

  task automatic t_disabled();
    cfg_en = 1'b0;
    xfer(1'b0, 16'h2000, 8'h00, 1'b0, 1'b0);
    chk("R1 disabled busy", n_busy, 0);
    chk("R1 disabled strobes", {rd_n, wr_n, ale}, 3'b110);
    cfg_en = 1'b1;
  endtask

  task automatic t_internal();
    xfer(1'b0, 16'h10FF, 8'h00, 1'b0, 1'b0);
    chk("R2 internal top ignored", n_busy, 0);
    xfer(1'b0, 16'h1100, 8'h00, 1'b0, 1'b0);
    chk("R2 first external served", n_busy, 3);
  endtask

  task automatic t_codes();
    for (int c = 0; c < 4; c++) begin
      int ex;
      ex = (c == 3) ? 2 : c;
      cfg_ws_lo = 2'(c);
      xfer(1'b0, 16'h3000 + 16'(c), 8'h00, 1'b0, 1'b0);
      chk($sformatf("R4 code%0d strobe", c), n_rd, ex + 1);
      chk($sformatf("R4 code%0d busy", c), n_busy, (c == 3) ? 6 : ex + 3);
      chk($sformatf("R6 code%0d ale", c), n_ale, 1);
      chk($sformatf("R6 code%0d ale addr", c), ale_lo, 8'(c));
      chk($sformatf("R7 code%0d rvalid", c), n_rv, 1);
      chk($sformatf("R7 code%0d rdata", c), got, 8'((8'(c) ^ 8'h5A) + 8'(ex)));
      if (c == 3) chk("R5 hold cycle", n_hold_ok, 1);
    end
    cfg_ws_lo = 2'd0;
  endtask

  task automatic t_sector();
    cfg_ws_lo = 2'd0; cfg_ws_hi = 2'd2; cfg_bound = 16'h8000;
    xfer(1'b0, 16'h8000, 8'h00, 1'b0, 1'b0);
    chk("R3 boundary is upper", n_rd, 3);
    xfer(1'b0, 16'h7FFF, 8'h00, 1'b0, 1'b0);
    chk("R3 below boundary is lower", n_rd, 1);
    cfg_bound = 16'h4000;
    xfer(1'b0, 16'h7FFF, 8'h00, 1'b0, 1'b0);
    chk("R3 moved boundary", n_rd, 3);
    cfg_bound = 16'h8000; cfg_ws_hi = 2'd0;
  endtask

  task automatic t_write();
    cfg_ws_hi = 2'd1;
    xfer(1'b1, 16'hC012, 8'hA5, 1'b0, 1'b0);
    chk("R8 write strobe", n_wr, 2);
    chk("R8 oe through release", n_oe, 3);
    chk("R8 write data", n_wbad, 0);
    chk("R7 no rvalid on write", n_rv, 0);
    chk("R12 no read strobe on write", n_rd, 0);
    cfg_ws_hi = 2'd0;
  endtask

  task automatic t_hibits();
    cfg_hi_bits = 4'd3;
    xfer(1'b0, 16'hABCD, 8'h00, 1'b0, 1'b0);
    chk("R9 three lines value", hi_snap, 8'h03);
    chk("R9 three lines oe", hioe_snap, 8'h07);
    cfg_hi_bits = 4'd0;
    xfer(1'b0, 16'hABCD, 8'h00, 1'b0, 1'b0);
    chk("R9 zero lines oe", hioe_snap, 8'h00);
    chk("R9 zero lines value", hi_snap, 8'h00);
    cfg_hi_bits = 4'd12;
    xfer(1'b0, 16'hABCD, 8'h00, 1'b0, 1'b0);
    chk("R9 saturated oe", hioe_snap, 8'hFF);
    chk("R9 saturated value", hi_snap, 8'hAB);
    cfg_hi_bits = 4'd8;
  endtask

  task automatic t_keeper();
    cfg_keep = 1'b1;
    xfer(1'b0, 16'h2233, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 keep after read", keep, 1);
    chk("R10 keep read value", d_out, 8'h69);
    xfer(1'b1, 16'h2234, 8'h3C, 1'b0, 1'b0);
    @(negedge clk);
    chk("R10 keep write value", d_out, 8'h3C);
    chk("R10 not driving", data_oe, 0);
    cfg_keep = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 keeper off flag", keep, 0);
    chk("R10 keeper off data", d_out, 0);
  endtask

  task automatic t_midcfg();
    cfg_ws_lo = 2'd2; cfg_hi_bits = 4'd8; cfg_keep = 1'b1;
    xfer(1'b0, 16'h2055, 8'h00, 1'b1, 1'b0);
    chk("R11 strobe kept", n_rd, 3);
    chk("R11 busy kept", n_busy, 5);
    chk("R11 hi oe kept", hioe_snap, 8'hFF);
    chk("R11 keeper kept", keep, 1);
    @(negedge clk); @(negedge clk);
    chk("R11 new keeper after", keep, 0);
    cfg_hi_bits = 4'd8;
  endtask

  task automatic t_busy_req();
    cfg_ws_lo = 2'd3;
    xfer(1'b0, 16'h2077, 8'h00, 1'b0, 1'b1);
    chk("R12 address held", n_drift, 0);
    chk("R12 no dual strobe", n_dual, 0);
    chk("R12 no write from busy req", n_wr, 0);
    chk("R12 busy length", n_busy, 6);
    @(negedge clk); @(negedge clk);
    chk("R12 idle after", busy, 0);
    cfg_ws_lo = 2'd0;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_disabled();
    t_internal();
    t_codes();
    t_sector();
    t_write();
    t_hibits();
    t_keeper();
    t_midcfg();
    t_busy_req();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule